// File: doc/BRIEF.md
# Two-Channel DMA Transfer Sequencer

This block is a small bus-mastering DMA engine with two independent channels. Each channel has a source pointer, a destination pointer, a transfer count and a mode word. A move is always two bus cycles on a single master port. The first is a four-clock read at the source pointer. The second is a four-clock write of the captured value at the destination pointer. After each move the pointers step and the count drops by one.

Channel requests come from external request pins. Each pin passes through a two-flop synchronizer before arbitration. A channel in free-running mode competes for the bus without any request. A per-channel priority bit decides which eligible channel wins. Two channels at the same level take turns. The engine never starts a bus cycle while the external hold request is high or while the processor lock is high. It raises a hold acknowledge whenever it is off the bus and hold is requested. A move that has already started always completes before the bus is released.

The host programs a channel through a write-only configuration port: it selects a channel and a register, then presents the data. A channel runs once the enable bit of its mode word is set.

Top module: `dma_seq`

## Requirements
- R1: While hold is high at a clock edge, no read cycle starts at that edge. hold_ack goes high one clock after hold is seen with the engine off the bus. hold_ack is never high together with bus_rd or bus_wr. A move already in progress completes first.
- R2: While lock is high at a clock edge, no read cycle starts at that edge. A pending channel starts only after lock has dropped.
- R3: Mode bit 8 is the channel priority, where 1 means high. When both channels are eligible and their priorities differ, every move goes to the high-priority channel until it stops being eligible.
- R4: With the engine idle and no hold or lock, take the first clock edge at which a request pin is sampled high as edge one. bus_rd is then high right after the fourth edge.
- R5: A move is bus_rd high for exactly 4 clocks with bus_addr equal to the source pointer. It is followed at once by bus_wr high for exactly 4 clocks with bus_addr equal to the destination pointer. bus_wdata holds the bus_rdata value captured in the last read clock.
- R6: Mode bits 5:4 select the request mode. In mode 10 (destination-synchronized) the engine stays off the bus for 2 extra clocks after each write. The gap from the last bus_wr clock to the next bus_rd of a channel that keeps requesting is 4 idle clocks in that mode and 2 in every other mode.
- R7: Mode bit 7 set selects byte moves. In that case bus_byte is high during the move, bus_wdata carries zero in bits 15:8 and the read byte in bits 7:0, and the pointers step by 1 instead of 2.
- R8: When both channels are eligible at equal priority, the winner alternates after every completed move.
- R9: The count drops by one after each move. With mode bit 6 (stop-on-zero) set, the channel clears its enable when the count reaches zero and makes no further moves. With bit 6 clear, it keeps running.
- R10: Mode bits 1:0 control the source pointer and bits 3:2 the destination pointer: 01 increments, 10 decrements, 00 and 11 leave it fixed. The step is applied after each move.
- R11: In mode 00 (free-running) an enabled channel moves data with its request pin low. In any other mode it needs its request pin and makes no move while the pin stays low.
- R12: After reset bus_rd, bus_wr and hold_ack are low and both channels are disabled. Configuration selects are 0 source, 1 destination, 2 count, 3 mode, and mode bit 9 is the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dreq | input | NCH | Per-channel request pins, asynchronous |
| hold | input | 1 | External bus hold request |
| lock | input | 1 | Processor bus lock |
| hold_ack | output | 1 | Hold acknowledge, engine off the bus |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | IW | Channel selected for the write |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 mode |
| cfg_wdata | input | AW | Configuration write data |
| bus_addr | output | AW | Bus address |
| bus_rd | output | 1 | Read strobe (fetch cycle) |
| bus_wr | output | 1 | Write strobe (deposit cycle) |
| bus_byte | output | 1 | Current move is a single byte |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, sampled in the last read clock |
| bus_ch | output | IW | Channel that owns the current move |

## Verification
The hardest situation to reach from the ports is a hold request that arrives while a move is halfway through. The move must still finish both of its cycles, and only then may the acknowledge appear. The bench waits until the read strobe is seen, raises hold on the next clock, and then checks two things: exactly one more move is counted, and the acknowledge holds with the bus quiet. The random phase goes further. It drives hold and lock pulses every clock while both channels run mixed modes, so grants get cancelled between arbitration and the first read clock.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int MODE_W  = 10;
  localparam int MB_SRC  = 0;
  localparam int MB_DST  = 2;
  localparam int MB_SYNC = 4;
  localparam int MB_TC   = 6;
  localparam int MB_BYTE = 7;
  localparam int MB_PRIO = 8;
  localparam int MB_EN   = 9;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_MODE = 2'd3;

  localparam logic [1:0] SYNC_FREE = 2'b00;
  localparam logic [1:0] SYNC_DST  = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GRANT,
    ST_FETCH,
    ST_DEP,
    ST_GAP
  } seq_state_e;
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] d,
  output logic [NCH-1:0] q
);
  for (genvar g = 0; g < NCH; g++) begin : g_sync
    logic meta;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta <= 1'b0;
        q[g] <= 1'b0;
      end else begin
        meta <= d[g];
        q[g] <= meta;
      end
    end
  end
endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int NCH = 2,
  parameter int IW  = 1
) (
  input  logic [NCH-1:0] elig,
  input  logic [NCH-1:0] prio,
  input  logic [IW-1:0]  last,
  output logic           any,
  output logic [IW-1:0]  win
);
  always_comb begin
    logic found;
    logic [IW-1:0] idx;
    any   = |elig;
    win   = last;
    found = 1'b0;
    // first pass: high-priority channels, round-robin after last served
    for (int o = 1; o <= NCH; o++) begin
      idx = IW'((int'(last) + o) % NCH);
      if (!found && elig[idx] && prio[idx]) begin
        win   = idx;
        found = 1'b1;
      end
    end
    // second pass: any eligible channel
    for (int o = 1; o <= NCH; o++) begin
      idx = IW'((int'(last) + o) % NCH);
      if (!found && elig[idx]) begin
        win   = idx;
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [AW-1:0]     cfg_wdata,
  input  logic              adv,
  output logic [AW-1:0]     src,
  output logic [AW-1:0]     dst,
  output logic [CW-1:0]     cnt,
  output logic [MODE_W-1:0] mode
);
  logic [AW-1:0] step;
  assign step = mode[MB_BYTE] ? AW'(1) : AW'(2);

  function automatic logic [AW-1:0] stepped(input logic [AW-1:0] p,
                                            input logic [1:0] dir,
                                            input logic [AW-1:0] s);
    case (dir)
      2'b01:   return p + s;
      2'b10:   return p - s;
      default: return p;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      src  <= '0;
      dst  <= '0;
      cnt  <= '0;
      mode <= '0;
    end else begin
      if (adv) begin
        src <= stepped(src, mode[MB_SRC+1:MB_SRC], step);
        dst <= stepped(dst, mode[MB_DST+1:MB_DST], step);
        cnt <= cnt - CW'(1);
        if (mode[MB_TC] && cnt == CW'(1)) mode[MB_EN] <= 1'b0;
      end
      if (cfg_we) begin
        case (cfg_sel)
          SEL_SRC:  src  <= cfg_wdata;
          SEL_DST:  dst  <= cfg_wdata;
          SEL_CNT:  cnt  <= cfg_wdata[CW-1:0];
          default:  mode <= cfg_wdata[MODE_W-1:0];
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int CW  = 16,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] dreq,
  input  logic           hold,
  input  logic           lock,
  output logic           hold_ack,
  input  logic           cfg_we,
  input  logic [IW-1:0]  cfg_ch,
  input  logic [1:0]     cfg_sel,
  input  logic [AW-1:0]  cfg_wdata,
  output logic [AW-1:0]  bus_addr,
  output logic           bus_rd,
  output logic           bus_wr,
  output logic           bus_byte,
  output logic [DW-1:0]  bus_wdata,
  input  logic [DW-1:0]  bus_rdata,
  output logic [IW-1:0]  bus_ch
);
  logic [NCH-1:0]    sreq, elig, prio;
  logic [AW-1:0]     src_a [NCH];
  logic [AW-1:0]     dst_a [NCH];
  logic [CW-1:0]     cnt_a [NCH];
  logic [MODE_W-1:0] mode_a [NCH];

  seq_state_e        state, state_n;
  logic [1:0]        phase;
  logic [IW-1:0]     cur, last, win;
  logic              req_any, xfer_done;
  logic [DW-1:0]     data_q;
  logic [MODE_W-1:0] cur_mode;

  dma_req_sync #(.NCH(NCH)) sync_i (.clk(clk), .rst(rst), .d(dreq), .q(sreq));

  assign xfer_done = (state == ST_DEP) && (phase == 2'd3);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma_chan #(.AW(AW), .CW(CW)) chan_i (
      .clk(clk), .rst(rst),
      .cfg_we(cfg_we && (cfg_ch == IW'(g))),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .adv(xfer_done && (cur == IW'(g))),
      .src(src_a[g]), .dst(dst_a[g]), .cnt(cnt_a[g]), .mode(mode_a[g])
    );
    assign elig[g] = mode_a[g][MB_EN] &&
                     ((mode_a[g][MB_SYNC+1:MB_SYNC] == SYNC_FREE) || sreq[g]);
    assign prio[g] = mode_a[g][MB_PRIO];
  end

  dma_arb #(.NCH(NCH), .IW(IW)) arb_i (
    .elig(elig), .prio(prio), .last(last), .any(req_any), .win(win)
  );

  assign cur_mode = mode_a[cur];

  always_comb begin
    state_n = state;
    case (state)
      ST_IDLE:  if (req_any && !hold && !lock) state_n = ST_GRANT;
      ST_GRANT: state_n = (hold || lock) ? ST_IDLE : ST_FETCH;
      ST_FETCH: if (phase == 2'd3) state_n = ST_DEP;
      ST_DEP:   if (phase == 2'd3)
                  state_n = (cur_mode[MB_SYNC+1:MB_SYNC] == SYNC_DST) ? ST_GAP : ST_IDLE;
      ST_GAP:   if (phase == 2'd1) state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      phase    <= '0;
      cur      <= '0;
      last     <= '0;
      data_q   <= '0;
      hold_ack <= 1'b0;
    end else begin
      state    <= state_n;
      phase    <= (state_n != state) ? 2'd0 : phase + 2'd1;
      hold_ack <= hold && (state_n != ST_FETCH) && (state_n != ST_DEP);
      if (state == ST_IDLE && state_n == ST_GRANT) cur <= win;
      if (state == ST_GRANT && state_n == ST_FETCH) last <= cur;
      if (state == ST_FETCH && phase == 2'd3)
        data_q <= cur_mode[MB_BYTE] ? {{(DW-8){1'b0}}, bus_rdata[7:0]} : bus_rdata;
    end
  end

  assign bus_rd    = (state == ST_FETCH);
  assign bus_wr    = (state == ST_DEP);
  assign bus_addr  = bus_rd ? src_a[cur] : dst_a[cur];
  assign bus_byte  = (bus_rd || bus_wr) && cur_mode[MB_BYTE];
  assign bus_wdata = data_q;
  assign bus_ch    = cur;
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          hold,
  input logic          lock,
  input logic          hold_ack,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          bus_byte,
  input logic [DW-1:0] bus_wdata
);
  logic [2:0] rd_len, wr_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_len <= '0;
      wr_len <= '0;
    end else begin
      rd_len <= bus_rd ? ((rd_len == 3'd7) ? rd_len : rd_len + 3'd1) : 3'd0;
      wr_len <= bus_wr ? ((wr_len == 3'd7) ? wr_len : wr_len + 3'd1) : 3'd0;
    end
  end

  p_ack_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    hold_ack |-> !(bus_rd || bus_wr));
  p_no_start_hold_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_rd) |-> !$past(hold));
  p_no_start_lock_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_rd) |-> !$past(lock));
  p_rd_len_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_rd) |-> rd_len == 3'd4);
  p_rd_then_wr_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_rd) |-> bus_wr);
  p_wr_len_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_wr) |-> wr_len == 3'd4);
  p_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));
  p_wdata_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && $past(bus_wr)) |-> $stable(bus_wdata));
  p_byte_upper_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_byte) |-> (bus_wdata[DW-1:8] == '0));
endmodule

bind dma_seq dma_seq_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .hold(hold), .lock(lock), .hold_ack(hold_ack),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_byte(bus_byte), .bus_wdata(bus_wdata)
);

// File: tb/dma_seq_tb_top.sv
`timescale 1ns/1ps
module dma_seq_tb_top;
  localparam int NCH = 2, AW = 16, DW = 16, CW = 16, IW = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [NCH-1:0] dreq = '0;
  logic hold = 1'b0, lock = 1'b0, hold_ack;
  logic cfg_we = 1'b0;
  logic [IW-1:0] cfg_ch = '0;
  logic [1:0] cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic [AW-1:0] bus_addr;
  logic bus_rd, bus_wr, bus_byte;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic [IW-1:0] bus_ch;

  function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
    return DW'(a * 16'd37) ^ 16'h5AC3;
  endfunction
  assign bus_rdata = memf(bus_addr);

  dma_seq #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .dreq(dreq), .hold(hold), .lock(lock), .hold_ack(hold_ack),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_byte(bus_byte),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ch(bus_ch)
  );

  int vecs = 0, errs = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model of channel state
  logic [AW-1:0] m_src [NCH];
  logic [AW-1:0] m_dst [NCH];
  logic [CW-1:0] m_cnt [NCH];
  logic [9:0]    m_mode [NCH];
  int xfers [NCH];
  int seq_log [0:255];
  int seq_n = 0;
  initial for (int i = 0; i < NCH; i++) begin
    m_src[i] = '0; m_dst[i] = '0; m_cnt[i] = '0; m_mode[i] = '0; xfers[i] = 0;
  end

  function automatic logic [9:0] mk(input int sd, input int dd, input int sy, input int tc,
                                    input int by, input int pr, input int en);
    return {1'(en), 1'(pr), 1'(by), 1'(tc), 2'(sy), 2'(dd), 2'(sd)};
  endfunction

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p, input logic [1:0] dir, input logic byt);
    logic [AW-1:0] s;
    s = byt ? AW'(1) : AW'(2);
    if (dir == 2'b01) return p + s;
    if (dir == 2'b10) return p - s;
    return p;
  endfunction

  // bus monitor
  logic prev_rd = 0, prev_wr = 0, prev_hold = 0, prev_lock = 0;
  int rd_len = 0, wr_len = 0, idle_cnt = 0, last_gap = 0, mch = 0;
  logic [DW-1:0] exp_data = '0;

  always @(negedge clk) begin
    if (rst) begin
      prev_rd = 0; prev_wr = 0; prev_hold = 0; prev_lock = 0; idle_cnt = 0;
    end else begin
      if (bus_rd && !prev_rd) begin
        mch = int'(bus_ch);
        chk("R9", "move on enabled channel", m_mode[mch][9], 1);
        chk("R10", "read address", bus_addr, m_src[mch]);
        chk("R1", "no start under hold", prev_hold, 0);
        chk("R2", "no start under lock", prev_lock, 0);
        exp_data = m_mode[mch][7] ? {8'h00, memf(bus_addr)[7:0]} : memf(bus_addr);
        last_gap = idle_cnt;
        rd_len = 0;
      end
      if (bus_rd) rd_len++;
      if (!bus_rd && prev_rd) chk("R5", "read length", rd_len, 4);
      if (bus_wr && !prev_wr) begin
        chk("R10", "write address", bus_addr, m_dst[mch]);
        chk("R5", "write data", bus_wdata, exp_data);
        chk("R7", "byte flag", bus_byte, m_mode[mch][7]);
        wr_len = 0;
      end
      if (bus_wr) wr_len++;
      if (!bus_wr && prev_wr) begin
        chk("R5", "write length", wr_len, 4);
        m_src[mch] = nxt(m_src[mch], m_mode[mch][1:0], m_mode[mch][7]);
        m_dst[mch] = nxt(m_dst[mch], m_mode[mch][3:2], m_mode[mch][7]);
        m_cnt[mch] = m_cnt[mch] - CW'(1);
        if (m_mode[mch][6] && m_cnt[mch] == '0) m_mode[mch][9] = 1'b0;
        xfers[mch]++;
        if (seq_n < 256) seq_log[seq_n] = mch;
        seq_n++;
        idle_cnt = 0;
      end
      if (!bus_rd && !bus_wr) idle_cnt++;
      if (hold_ack && (bus_rd || bus_wr)) chk("R1", "ack while on bus", 1, 0);
      prev_rd = bus_rd; prev_wr = bus_wr; prev_hold = hold; prev_lock = lock;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wcfg(input int ch, input int sel, input logic [AW-1:0] d);
    cfg_we = 1'b1; cfg_ch = IW'(ch); cfg_sel = 2'(sel); cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    case (sel)
      0: m_src[ch] = d;
      1: m_dst[ch] = d;
      2: m_cnt[ch] = d[CW-1:0];
      default: m_mode[ch] = d[9:0];
    endcase
  endtask

  task automatic setup(input int ch, input logic [AW-1:0] s, input logic [AW-1:0] d,
                       input int cnt, input logic [9:0] md);
    wcfg(ch, 0, s); wcfg(ch, 1, d); wcfg(ch, 2, AW'(cnt)); wcfg(ch, 3, AW'(md));
  endtask

  task automatic wait_quiet(input int maxc);
    for (int n = 0; n < maxc && (m_mode[0][9] || m_mode[1][9]); n++) tick(1);
    tick(4);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      vecs++; errs++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    int n, b0, b1;
    void'($urandom(32'd4711));
    tick(3);
    rst = 1'b0;
    // R12: reset state
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R12", "quiet after reset", {bus_rd, bus_wr, hold_ack}, 0);
    end
    tick(1);

    // R11/R4: source-synchronized channel waits for its pin, then fixed latency
    setup(0, 16'h1000, 16'h2000, 3, mk(1, 1, 1, 1, 0, 0, 1));
    tick(20);
    chk("R11", "no move without request", xfers[0], 0);
    dreq[0] = 1'b1;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (bus_rd) break;
    end
    chk("R4", "request to first read edges", n, 4);
    tick(1);
    wait_quiet(200);
    chk("R9", "stop after count", xfers[0], 3);
    chk("R6", "gap non-dest mode", last_gap, 2);
    tick(30);
    chk("R9", "no move after stop", xfers[0], 3);
    dreq[0] = 1'b0;

    // R6: destination-synchronized gap, decrementing source
    setup(1, 16'h3000, 16'h4000, 2, mk(2, 1, 2, 1, 0, 0, 1));
    dreq[1] = 1'b1;
    wait_quiet(200);
    dreq[1] = 1'b0;
    chk("R9", "dest-sync count", xfers[1], 2);
    chk("R6", "gap dest mode", last_gap, 4);

    // R7/R10/R11: free-running byte moves, source decrement, destination fixed
    b0 = xfers[0];
    setup(0, 16'h0105, 16'h0200, 4, mk(2, 0, 0, 1, 1, 0, 1));
    wait_quiet(300);
    chk("R11", "free-running without request", xfers[0] - b0, 4);
    chk("R10", "byte step source", m_src[0], 16'h0101);

    // R3: priority
    lock = 1'b1;
    setup(0, 16'h5000, 16'h6000, 3, mk(1, 1, 0, 1, 0, 0, 1));
    setup(1, 16'h7000, 16'h8000, 3, mk(1, 1, 0, 1, 0, 1, 1));
    seq_n = 0;
    lock = 1'b0;
    wait_quiet(400);
    for (int i = 0; i < 6; i++) chk("R3", "priority order", seq_log[i], (i < 3) ? 1 : 0);

    // R8: equal priority alternates
    lock = 1'b1;
    setup(0, 16'h0A00, 16'h0B00, 3, mk(1, 2, 0, 1, 0, 0, 1));
    setup(1, 16'h0C00, 16'h0D00, 3, mk(0, 1, 0, 1, 0, 0, 1));
    seq_n = 0;
    lock = 1'b0;
    wait_quiet(400);
    for (int i = 1; i < 6; i++) chk("R8", "alternation", seq_log[i] != seq_log[i-1], 1);

    // R1: hold before start
    hold = 1'b1;
    b0 = xfers[0];
    setup(0, 16'h1100, 16'h1200, 2, mk(1, 1, 0, 1, 0, 0, 1));
    tick(20);
    @(negedge clk);
    chk("R1", "hold_ack while held", hold_ack, 1);
    chk("R1", "no move under hold", xfers[0] - b0, 0);
    tick(1);
    hold = 1'b0;
    wait_quiet(200);
    chk("R1", "moves after hold", xfers[0] - b0, 2);

    // R1: hold arriving mid-move
    b0 = xfers[0];
    setup(0, 16'h1300, 16'h1400, 3, mk(1, 1, 0, 1, 0, 0, 1));
    do @(negedge clk); while (!bus_rd);
    tick(1);
    hold = 1'b1;
    tick(12);
    @(negedge clk);
    chk("R1", "ack after move completes", hold_ack, 1);
    chk("R1", "in-flight move finished", xfers[0] - b0, 1);
    tick(1);
    hold = 1'b0;
    wait_quiet(200);
    chk("R1", "rest after hold", xfers[0] - b0, 3);

    // R2: lock
    lock = 1'b1;
    b1 = xfers[1];
    setup(1, 16'h1500, 16'h1600, 2, mk(0, 0, 0, 1, 0, 0, 1));
    tick(20);
    chk("R2", "no move under lock", xfers[1] - b1, 0);
    lock = 1'b0;
    wait_quiet(200);
    chk("R2", "moves after lock", xfers[1] - b1, 2);

    // R9: stop-on-zero clear keeps running
    lock = 1'b1;
    b0 = xfers[0];
    setup(0, 16'h1700, 16'h1800, 1, mk(1, 1, 0, 0, 0, 0, 1));
    lock = 1'b0;
    tick(50);
    lock = 1'b1;
    tick(12);
    chk("R9", "runs past zero", (xfers[0] - b0) >= 3, 1);
    wcfg(0, 3, AW'(mk(1, 1, 0, 0, 0, 0, 0)));
    b0 = xfers[0];
    lock = 1'b0;
    tick(20);
    chk("R9", "stopped by disable", xfers[0] - b0, 0);

    // random mixed runs
    for (int it = 0; it < 25; it++) begin
      int cn [NCH];
      int bs [NCH];
      lock = 1'b1;
      for (int c = 0; c < NCH; c++) begin
        cn[c] = 1 + int'($urandom % 4);
        bs[c] = xfers[c];
        setup(c, AW'($urandom), AW'($urandom), cn[c],
              mk(int'($urandom % 4), int'($urandom % 4), int'($urandom % 3), 1,
                 int'($urandom % 2), int'($urandom % 2), 1));
      end
      for (int c = 0; c < 3000 && (m_mode[0][9] || m_mode[1][9]); c++) begin
        dreq = {($urandom % 4) != 0, ($urandom % 4) != 0};
        hold = ($urandom % 8) == 0;
        lock = ($urandom % 10) == 0;
        tick(1);
      end
      hold = 1'b0; lock = 1'b0; dreq = '0;
      tick(4);
      for (int c = 0; c < NCH; c++) chk("R9", "random run count", xfers[c] - bs[c], cn[c]);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule